// File: doc/BRIEF.md
# Programmable CRC-32 Engine with Register Port

This block keeps a 32-bit running checksum that software drives through a small register port. Software first chooses a generator polynomial and a seed, then writes a control word. The control word reloads the running value from the seed and sets the bit-reordering options. After that, each 32-bit word written to the data offset is folded into the running value within a single clock. A read of the data offset returns the running value, reordered for output if that option is on.

The polynomial and the seed are both held in normal (MSB-first) bit order. The reordering options let the same datapath produce reflected checksums such as CRC-32 (register value 0x04C11DB7) and CRC-32C (register value 0x1EDC6F41). For these, software sets full-word input reversal and output reversal, packs the bytes into words little-endian, and applies the final inversion itself.

The port has no back-pressure. A write is taken on every clock edge where `wr_en` is high. Read data is combinational from `addr` while `rd_en` is high and is zero otherwise. The data flowing in is only one word per write strobe, so there is no valid/ready pair: the engine never stalls.

Top module: `crcu_top`

## Requirements
- R1: After reset, the data offset reads 0xFFFFFFFF, the control offset reads 0, the seed offset reads 0xFFFFFFFF and the polynomial offset reads 0x04C11DB7.
- R2: The register map uses these byte offsets: 0x00 data, 0x08 control, 0x10 seed, 0x14 polynomial. Seed and polynomial read back the last value written. The control offset reads back bits 7:5 as written, and all its other bits read 0.
- R3: Writing the control offset with bit 0 set loads the running value from the seed register at that edge. Bit 0 is not stored and always reads 0.
- R4: A write to the data offset updates the running value at that edge by 32 LFSR steps. The steps take the reordered word MSB first, and each step computes `fb = crc[31] ^ bit; crc = (crc << 1) ^ (fb ? poly : 0)`.
- R5: Control bits 6:5 select input reordering before folding: 00 none, 01 bit order reversed within each byte, 10 reversed within each 16-bit half, 11 reversed across the whole 32-bit word.
- R6: Control bit 7 set makes a read of the data offset return the running value bit-reversed across all 32 bits. Clear, the read returns the value as stored.
- R7: Two configurations reproduce the byte-serial reflected checksums, after software inverts the read value, on little-endian packed bytes. The first is polynomial 0x04C11DB7 with control 0xE1 and seed 0xFFFFFFFF (CRC-32). The second is polynomial 0x1EDC6F41 with the same control and seed (CRC-32C).
- R8: Writes to unmapped offsets change no register. Reads of unmapped offsets return 0, and `rd_data` is 0 whenever `rd_en` is low.
- R9: The running value changes only on a data write or a control write with bit 0 set. Writing the seed does not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| rd_en | input | 1 | Read enable for the combinational read path |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wr_data | input | W (32) | Write data |
| rd_data | output | W (32) | Read data, zero when idle or unmapped |

## Verification
The bench builds the block with its defaults: a 32-bit word and a 5-bit byte offset. This covers every mapped offset plus unmapped holes at 0x04, 0x0C, 0x18 and 0x1C. With the 32-bit width, the reflected CRC-32 and CRC-32C results can be compared against a byte-serial model on packed ASCII strings. Random sessions draw polynomial, seed, reorder mode and output flag, so all four input orderings meet arbitrary polynomials. Directed cases cover seed reload, seed writes between data words and writes into the holes.

// File: rtl/crcu_pkg.sv
package crcu_pkg;
  localparam int OFF_DATA = 0;
  localparam int OFF_CTRL = 8;
  localparam int OFF_SEED = 16;
  localparam int OFF_POLY = 20;

  localparam int CTL_LOAD   = 0;
  localparam int CTL_MODE_L = 5;
  localparam int CTL_OUTREV = 7;

  typedef enum logic [1:0] {
    REV_NONE = 2'b00,
    REV_BYTE = 2'b01,
    REV_HALF = 2'b10,
    REV_WORD = 2'b11
  } rev_mode_e;
endpackage

// File: rtl/crcu_reorder.sv
module crcu_reorder
  import crcu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  rev_mode_e    mode,
  output logic [W-1:0] dout
);
  logic [W-1:0] by_byte, by_half, by_word;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int SRC_B = (i / 8) * 8 + 7 - (i % 8);
    localparam int SRC_H = (i / 16) * 16 + 15 - (i % 16);
    localparam int SRC_W = W - 1 - i;
    assign by_byte[i] = din[SRC_B];
    assign by_half[i] = din[SRC_H];
    assign by_word[i] = din[SRC_W];
  end

  always_comb begin
    unique case (mode)
      REV_BYTE: dout = by_byte;
      REV_HALF: dout = by_half;
      REV_WORD: dout = by_word;
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/crcu_fold.sv
module crcu_fold #(
  parameter int W = 32
) (
  input  logic [W-1:0] state,
  input  logic [W-1:0] poly,
  input  logic [W-1:0] word,
  output logic [W-1:0] next
);
  logic [W-1:0] acc;
  logic         fb;

  always_comb begin
    acc = state;
    fb  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      fb  = acc[W-1] ^ word[i];
      acc = {acc[W-2:0], 1'b0} ^ (fb ? poly : '0);
    end
    next = acc;
  end
endmodule

// File: rtl/crcu_top.sv
module crcu_top
  import crcu_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      rd_data
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFF_SEED);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(OFF_POLY);

  logic [W-1:0] crc_q, seed_q, poly_q;
  rev_mode_e    mode_q;
  logic         outrev_q;

  logic [W-1:0] word_ord, crc_next, crc_rev, crc_view, ctrl_view;

  logic wr_data_hit, wr_ctrl_hit, wr_seed_hit, wr_poly_hit;
  assign wr_data_hit = wr_en && (addr == A_DATA);
  assign wr_ctrl_hit = wr_en && (addr == A_CTRL);
  assign wr_seed_hit = wr_en && (addr == A_SEED);
  assign wr_poly_hit = wr_en && (addr == A_POLY);

  crcu_reorder #(.W(W)) u_in_ord (
    .din  (wr_data),
    .mode (mode_q),
    .dout (word_ord)
  );

  crcu_fold #(.W(W)) u_fold (
    .state (crc_q),
    .poly  (poly_q),
    .word  (word_ord),
    .next  (crc_next)
  );

  crcu_reorder #(.W(W)) u_out_ord (
    .din  (crc_q),
    .mode (REV_WORD),
    .dout (crc_rev)
  );

  assign crc_view = outrev_q ? crc_rev : crc_q;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTL_OUTREV] = outrev_q;
    ctrl_view[CTL_MODE_L +: 2] = mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= SEED_RST[W-1:0];
      seed_q   <= SEED_RST[W-1:0];
      poly_q   <= POLY_RST[W-1:0];
      mode_q   <= REV_NONE;
      outrev_q <= 1'b0;
    end else begin
      if (wr_data_hit) crc_q <= crc_next;
      if (wr_ctrl_hit) begin
        mode_q   <= rev_mode_e'(wr_data[CTL_MODE_L +: 2]);
        outrev_q <= wr_data[CTL_OUTREV];
        if (wr_data[CTL_LOAD]) crc_q <= seed_q;
      end
      if (wr_seed_hit) seed_q <= wr_data;
      if (wr_poly_hit) poly_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (addr)
        A_DATA:  rd_data = crc_view;
        A_CTRL:  rd_data = ctrl_view;
        A_SEED:  rd_data = seed_q;
        A_POLY:  rd_data = poly_q;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/crcu_checker.sv
module crcu_checker #(
  parameter int W      = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      rd_data,
  input logic [W-1:0]      crc_q,
  input logic [W-1:0]      seed_q
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(crcu_pkg::OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(crcu_pkg::OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(crcu_pkg::OFF_SEED);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(crcu_pkg::OFF_POLY);

  logic mapped;
  assign mapped = (addr == A_DATA) || (addr == A_CTRL) ||
                  (addr == A_SEED) || (addr == A_POLY);

  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && wr_data[0]) |=> (crc_q == $past(seed_q)));

  p_ctrl_bit0_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |-> (rd_data[0] == 1'b0));

  p_seed_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEED) |=> (seed_q == $past(wr_data)));

  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |-> (rd_data == '0));

  p_idle_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));

  p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == A_DATA || addr == A_CTRL)) |=> $stable(crc_q));
endmodule

bind crcu_top crcu_checker #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .crc_q   (crc_q),
  .seed_q  (seed_q)
);

// File: tb/crcu_top_bench.sv
module crcu_top_bench;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  rd_data;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  crcu_top u_crcu_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  function automatic logic [31:0] rev32(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  function automatic logic [31:0] order_in(input logic [31:0] w, input logic [1:0] m);
    logic [31:0] bw;
    bw = {rev8(w[31:24]), rev8(w[23:16]), rev8(w[15:8]), rev8(w[7:0])};
    case (m)
      2'b01:   return bw;
      2'b10:   return {bw[23:16], bw[31:24], bw[7:0], bw[15:8]};
      2'b11:   return rev32(w);
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] lfsr_word(input logic [31:0] c, input logic [31:0] p,
                                            input logic [31:0] w);
    logic [31:0] s;
    s = c;
    for (int i = 31; i >= 0; i--) begin
      if (s[31] ^ w[i]) s = (s << 1) ^ p;
      else              s = s << 1;
    end
    return s;
  endfunction

  function automatic logic [31:0] refl_byte(input logic [31:0] c, input logic [31:0] rp,
                                            input logic [7:0] b);
    logic [31:0] s;
    s = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) s = s[0] ? ((s >> 1) ^ rp) : (s >> 1);
    return s;
  endfunction

  logic [W-1:0] v, exp_crc, keep;
  logic [7:0] msg [0:8];

  initial begin
    void'($urandom(32'h5EED_C0DE));
    msg[0]="1"; msg[1]="2"; msg[2]="3"; msg[3]="4"; msg[4]="5";
    msg[5]="6"; msg[6]="7"; msg[7]="8"; msg[8]="9";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h00, v); check("R1 data reset", v, 32'hFFFF_FFFF);
    rd(5'h08, v); check("R1 ctrl reset", v, 32'h0);
    rd(5'h10, v); check("R1 seed reset", v, 32'hFFFF_FFFF);
    rd(5'h14, v); check("R1 poly reset", v, 32'h04C1_1DB7);

    // R2 readback, R3 bit0 not stored
    wr(5'h14, 32'h1EDC_6F41); rd(5'h14, v); check("R2 poly readback", v, 32'h1EDC_6F41);
    wr(5'h10, 32'h1234_5678); rd(5'h10, v); check("R2 seed readback", v, 32'h1234_5678);
    wr(5'h08, 32'hFFFF_FF7F); rd(5'h08, v); check("R2 R3 ctrl readback", v, 32'h0000_0060);
    wr(5'h08, 32'h0000_0001); rd(5'h08, v); check("R3 ctrl bit0 reads 0", v, 32'h0);
    rd(5'h00, v); check("R3 seed loaded", v, 32'h1234_5678);

    // R9 seed write leaves running value
    wr(5'h10, 32'hAAAA_5555); rd(5'h00, v); check("R9 seed write no effect", v, 32'h1234_5678);
    wr(5'h14, 32'h04C1_1DB7); rd(5'h00, v); check("R9 poly write no effect", v, 32'h1234_5678);

    // R4 directed fold
    wr(5'h08, 32'h1);
    wr(5'h00, 32'h3132_3334);
    exp_crc = lfsr_word(32'hAAAA_5555, 32'h04C1_1DB7, 32'h3132_3334);
    rd(5'h00, v); check("R4 single fold", v, exp_crc);
    wr(5'h00, 32'h0);
    exp_crc = lfsr_word(exp_crc, 32'h04C1_1DB7, 32'h0);
    rd(5'h00, v); check("R4 zero word fold", v, exp_crc);

    // R8 unmapped writes and reads
    rd(5'h00, keep);
    wr(5'h04, 32'hDEAD_BEEF); wr(5'h0C, 32'hDEAD_BEEF);
    wr(5'h18, 32'hDEAD_BEEF); wr(5'h1C, 32'hDEAD_BEEF);
    rd(5'h00, v); check("R8 data untouched", v, keep);
    rd(5'h08, v); check("R8 ctrl untouched", v, 32'h0);
    rd(5'h10, v); check("R8 seed untouched", v, 32'hAAAA_5555);
    rd(5'h14, v); check("R8 poly untouched", v, 32'h04C1_1DB7);
    rd(5'h04, v); check("R8 unmapped read 0x04", v, 32'h0);
    rd(5'h1C, v); check("R8 unmapped read 0x1C", v, 32'h0);
    @(negedge clk); addr = 5'h10; #1 check("R8 idle read zero", rd_data, 32'h0);

    // R7 model sanity and reflected checksums
    exp_crc = 32'hFFFF_FFFF;
    for (int i = 0; i < 9; i++) exp_crc = refl_byte(exp_crc, 32'hEDB8_8320, msg[i]);
    check("R7 model check value", ~exp_crc, 32'hCBF4_3926);

    for (int pass = 0; pass < 2; pass++) begin
      logic [31:0] np, rp;
      np = (pass == 0) ? 32'h04C1_1DB7 : 32'h1EDC_6F41;
      rp = (pass == 0) ? 32'hEDB8_8320 : 32'h82F6_3B78;
      wr(5'h14, np); wr(5'h10, 32'hFFFF_FFFF); wr(5'h08, 32'hE1);
      wr(5'h00, {msg[3], msg[2], msg[1], msg[0]});
      wr(5'h00, {msg[7], msg[6], msg[5], msg[4]});
      exp_crc = 32'hFFFF_FFFF;
      for (int i = 0; i < 8; i++) exp_crc = refl_byte(exp_crc, rp, msg[i]);
      rd(5'h00, v);
      check(pass == 0 ? "R7 CRC-32 of 12345678" : "R7 CRC-32C of 12345678", ~v, ~exp_crc);
    end

    // R4 R5 R6 random sessions
    for (int s = 0; s < 160; s++) begin
      logic [31:0] p, sd, w, ctl;
      logic [1:0]  m;
      logic        o;
      int          nw;
      p  = $urandom | 32'h1;
      sd = $urandom;
      m  = 2'(s % 4);
      o  = 1'($urandom);
      nw = 1 + int'($urandom % 6);
      ctl = {24'h0, o, m, 5'b00001};
      wr(5'h14, p); wr(5'h10, sd); wr(5'h08, ctl);
      exp_crc = sd;
      for (int k = 0; k < nw; k++) begin
        w = $urandom;
        wr(5'h00, w);
        exp_crc = lfsr_word(exp_crc, p, order_in(w, m));
      end
      rd(5'h00, v);
      check(o ? "R5 R6 R4 random reversed out" : "R5 R4 random plain out",
            v, o ? rev32(exp_crc) : exp_crc);
    end

    finish_run();
  end
endmodule